// File: doc/BRIEF.md
# Inverting GPIO Port

This block is one general-purpose I/O port with up to eight pins. Software controls it with single-byte register writes and reads on a simple strobe bus. Four registers are provided: a per-pin direction mask, a data byte, a per-pin inversion mask, and a control byte. The control byte holds the port enable and the choice between push-pull and open-drain output drivers.

The inversion mask works on both paths. A written data bit is XORed with its inversion bit before it reaches the pin. A pin level that is read back is XORed with the same bit, so software always sees logical values. Pin inputs pass through a two-flop synchronizer before they can be read.

A parameter sets how many pins are built. Register bits above that count do not exist: they read as zero and writes to them have no effect. The port drives no pin and samples no input until it is enabled.

Top module: `gpio_inv_port`

## Requirements
- R1: After reset, the direction register reads all ones on the implemented bits (every pin is an input). The data, inversion and control registers read 0, and no pin is driven.
- R2: Register map by `addr`: 0 direction, 1 data, 2 inversion, 3 control. In the control register, bit 0 is the port enable and bit 1 selects push-pull (1) or open-drain (0); its other bits read 0. A write is taken at a clock edge where `wr_en` is high. For a clock edge where `rd_en` is high, the addressed value appears on `rdata` after that edge and stays there until the next read.
- R3: While the enable bit is 0, `pin_oe` is all zero. The synchronizer is also held at zero, so a data read returns the inversion mask.
- R4: A direction bit of 1 makes that pin an input, and its `pin_oe` is 0. A direction bit of 0 makes it an output.
- R5: In push-pull mode, every enabled output pin has `pin_oe` = 1 and `pin_out` = data bit XOR inversion bit. Any pin that is not driven has `pin_out` = 0.
- R6: In open-drain mode, `pin_out` is always 0. An enabled output pin whose level (data XOR inversion) is 1 is released (`pin_oe` = 0). A pin whose level is 0 is pulled low (`pin_oe` = 1).
- R7: A data read returns the synchronized pin level XOR the inversion mask. Take a change on `pin_in` before clock edge k. A read strobe sampled at edge k+2 or later returns the new level. A strobe sampled at edge k+1 still returns the old level.
- R8: With `PIN_COUNT` below 8, `rdata` bits at and above `PIN_COUNT` read 0 for the direction, data and inversion registers. Writes to those bits are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register select |
| wdata | input | REG_W | Write data |
| rdata | output | REG_W | Read data, registered |
| pin_in | input | PIN_COUNT | Pin input levels |
| pin_out | output | PIN_COUNT | Pin output levels |
| pin_oe | output | PIN_COUNT | Pin output enables |

## Verification
Several rules are checked by the assertions on every cycle:
- no pin is driven while the port is disabled;
- no input pin is driven;
- an open-drain port never drives a high level;
- an undriven pin never carries a high output;
- unimplemented read bits stay zero.

Other behaviour can only be shown by the bench scenarios. These cover the values XORed through the inversion mask in both directions, and the exact read latency of the two-flop synchronizer. They also cover the reset contents and the masking of writes on a five-pin build.

// File: rtl/gpio_inv_port.sv
module gpio_inv_port #(
  parameter int PIN_COUNT = 8,
  parameter int REG_W     = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [1:0]           addr,
  input  logic [REG_W-1:0]     wdata,
  output logic [REG_W-1:0]     rdata,
  input  logic [PIN_COUNT-1:0] pin_in,
  output logic [PIN_COUNT-1:0] pin_out,
  output logic [PIN_COUNT-1:0] pin_oe
);
  localparam logic [1:0] SEL_DIR = 2'd0;
  localparam logic [1:0] SEL_DAT = 2'd1;
  localparam logic [1:0] SEL_INV = 2'd2;
  localparam logic [1:0] SEL_CTL = 2'd3;
  localparam logic [PIN_COUNT-1:0] ALL_ONE = '1;

  logic [PIN_COUNT-1:0] dir_q, dat_q, inv_q, sync1_q, sync2_q;
  logic                 en_q, pp_q;
  logic [PIN_COUNT-1:0] level, drive;
  logic [REG_W-1:0]     rd_mux;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= ALL_ONE;
      dat_q <= '0;
      inv_q <= '0;
      en_q  <= 1'b0;
      pp_q  <= 1'b0;
    end else if (wr_en) begin
      case (addr)
        SEL_DIR: dir_q <= wdata[PIN_COUNT-1:0];
        SEL_DAT: dat_q <= wdata[PIN_COUNT-1:0];
        SEL_INV: inv_q <= wdata[PIN_COUNT-1:0];
        default: begin
          en_q <= wdata[0];
          pp_q <= wdata[1];
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else if (!en_q) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
    end
  end

  assign level   = dat_q ^ inv_q;
  assign drive   = {PIN_COUNT{en_q}} & ~dir_q;
  assign pin_oe  = pp_q ? drive : (drive & ~level);
  assign pin_out = pp_q ? (drive & level) : '0;

  always_comb begin
    rd_mux = '0;
    case (addr)
      SEL_DIR: rd_mux[PIN_COUNT-1:0] = dir_q;
      SEL_DAT: rd_mux[PIN_COUNT-1:0] = sync2_q ^ inv_q;
      SEL_INV: rd_mux[PIN_COUNT-1:0] = inv_q;
      SEL_CTL: begin
        rd_mux[0] = en_q;
        rd_mux[1] = pp_q;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end
endmodule

// File: rtl/gpio_inv_port_chk.sv
module gpio_inv_port_chk #(
  parameter int PIN_COUNT = 8,
  parameter int REG_W     = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 en_q,
  input logic                 pp_q,
  input logic [PIN_COUNT-1:0] dir_q,
  input logic [PIN_COUNT-1:0] pin_oe,
  input logic [PIN_COUNT-1:0] pin_out,
  input logic [REG_W-1:0]     rdata
);
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> pin_oe == '0);
  a_r3_off_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> pin_oe == '0);
  a_r4_inputs_undriven: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & dir_q) == '0);
  a_r5_undriven_low: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~pin_oe) == '0);
  a_r6_od_never_high: assert property (@(posedge clk) disable iff (!rst_n)
    !pp_q |-> pin_out == '0);
  a_r8_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata >> PIN_COUNT) == '0);
endmodule

bind gpio_inv_port gpio_inv_port_chk #(.PIN_COUNT(PIN_COUNT), .REG_W(REG_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .en_q(en_q), .pp_q(pp_q), .dir_q(dir_q),
  .pin_oe(pin_oe), .pin_out(pin_out), .rdata(rdata)
);

// File: tb/gpio_inv_port_tb.sv
`timescale 1ns/100ps
module gpio_inv_port_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, sel5 = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0, rdata, rdata5;
  logic [7:0] pin_in = '0, pin_out, pin_oe;
  logic [4:0] pin_out5, pin_oe5;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  logic [7:0] m_dir = 8'hFF, m_dat = 8'h00, m_inv = 8'h00;
  logic m_en = 1'b0, m_pp = 1'b0;

  always #2.5 clk = ~clk;

  gpio_inv_port #(.PIN_COUNT(8), .REG_W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en & ~sel5), .rd_en(rd_en & ~sel5),
    .addr(addr), .wdata(wdata), .rdata(rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe));

  gpio_inv_port #(.PIN_COUNT(5), .REG_W(8)) dut5_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en & sel5), .rd_en(rd_en & sel5),
    .addr(addr), .wdata(wdata), .rdata(rdata5), .pin_in(pin_in[4:0]),
    .pin_out(pin_out5), .pin_oe(pin_oe5));

  function automatic logic [7:0] exp_oe();
    logic [7:0] drv = {8{m_en}} & ~m_dir;
    return m_pp ? drv : (drv & ~(m_dat ^ m_inv));
  endfunction
  function automatic logic [7:0] exp_out();
    return m_pp ? (exp_oe() & (m_dat ^ m_inv)) : 8'h00;
  endfunction
  function automatic logic [7:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0: return m_dir;
      2'd1: return (m_en ? pin_in : 8'h00) ^ m_inv;
      2'd2: return m_inv;
      default: return {6'd0, m_pp, m_en};
    endcase
  endfunction

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (!sel5) begin
      case (a)
        2'd0: m_dir = d;
        2'd1: m_dat = d;
        2'd2: m_inv = d;
        default: begin m_en = d[0]; m_pp = d[1]; end
      endcase
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = sel5 ? rdata5 : rdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    logic [7:0] v;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    check("R1 oe at reset", pin_oe, 8'h00);
    rd(2'd0, v); check("R1 dir reset", v, 8'hFF);
    rd(2'd1, v); check("R1 data reset", v, 8'h00);
    rd(2'd2, v); check("R1 inv reset", v, 8'h00);
    rd(2'd3, v); check("R1 ctl reset", v, 8'h00);

    wr(2'd2, 8'h0F); wr(2'd1, 8'hA5); wr(2'd0, 8'h00);
    check("R3 disabled no drive", pin_oe, 8'h00);
    wr(2'd3, 8'h03);
    check("R5 pp oe", pin_oe, 8'hFF);
    check("R5 pp out", pin_out, 8'hAA);
    rd(2'd1, v); check("R2 data reg not stored value", v, exp_rd(2'd1));
    wr(2'd3, 8'h01);
    check("R6 od oe", pin_oe, 8'h55);
    check("R6 od out", pin_out, 8'h00);
    wr(2'd0, 8'hF0);
    check("R4 inputs released", pin_oe, 8'h05);
    rd(2'd3, v); check("R2 ctl readback", v, 8'h01);

    wr(2'd3, 8'h00);
    pin_in = 8'hFF; settle();
    check("R3 off oe", pin_oe, 8'h00);
    rd(2'd1, v); check("R3 off read", v, 8'h0F);

    wr(2'd2, 8'h00); wr(2'd3, 8'h03);
    pin_in = 8'h00; settle();
    @(negedge clk) pin_in = 8'h3C;
    rd(2'd1, v); check("R7 early read old", v, 8'h00);
    @(negedge clk) pin_in = 8'hC3;
    @(negedge clk);
    rd(2'd1, v); check("R7 boundary read new", v, 8'hC3);
    wr(2'd2, 8'h81); settle();
    rd(2'd1, v); check("R7 inverted read", v, 8'h42);

    sel5 = 1'b1;
    rd(2'd0, v); check("R8 R1 five-pin dir reset", v, 8'h1F);
    wr(2'd0, 8'hFF); wr(2'd1, 8'hFF); wr(2'd2, 8'hFF); wr(2'd3, 8'hFF);
    rd(2'd0, v); check("R8 dir upper", v, 8'h1F);
    rd(2'd2, v); check("R8 inv upper", v, 8'h1F);
    rd(2'd3, v); check("R2 ctl unused bits", v, 8'h03);
    wr(2'd0, 8'h00); wr(2'd1, 8'hE0); wr(2'd2, 8'h00);
    check("R8 five-pin out", {3'd0, pin_out5}, 8'h00);
    check("R8 five-pin oe", {3'd0, pin_oe5}, 8'h1F);
    rd(2'd1, v); check("R8 data upper", v & 8'hE0, 8'h00);
    sel5 = 1'b0;

    for (int i = 0; i < 300; i++) begin
      case ($urandom % 3)
        0: wr(2'($urandom % 4), 8'($urandom));
        1: pin_in = 8'($urandom);
        default: wr(2'd3, {6'd0, 2'($urandom)});
      endcase
      settle();
      check(m_pp ? "R5 rand oe" : "R6 rand oe", pin_oe, exp_oe());
      check(m_pp ? "R5 rand out" : "R6 rand out", pin_out, exp_out());
      begin
        logic [1:0] a = 2'($urandom % 4);
        rd(a, v); check("R2 R7 rand read", v, exp_rd(a));
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule